// File: doc/BRIEF.md
# Oversampled Serial Receiver with Status FIFO

This block turns an asynchronous serial line into bytes. A strobe at sixteen times the bit rate paces the work. A falling edge on the line arms the receiver. It then waits half a bit and looks at the line again. If the line has gone back high, the edge is treated as noise and dropped. If the line is still low, the receiver samples 5 to 8 data bits, an optional parity bit and one stop bit, each at the centre of its bit cell.

Each finished character goes into a 16-entry queue together with three flags of its own: parity error, framing error and break. A break is a line held low for the whole frame. The host reads the oldest entry at the output ports and removes it with a one-cycle read strobe. The block also provides:
- a one-cycle overrun pulse,
- a character-timeout level,
- an active-low ready line for DMA-style transfers, which goes low when the queue reaches a chosen fill level.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset the queue is empty: `fifo_count`=0, `data_ready`=0, `timeout`=0, `rx_rdy_n`=1, and the head outputs (`rd_data`, `rd_perr`, `rd_ferr`, `rd_brk`) read 0 whenever the queue is empty.
- R2: A high-to-low transition of `rxd` seen on a `tick16` strobe starts a frame. If `rxd` is high at the 8th strobe after that transition (the centre of the start bit), the frame is abandoned and nothing is queued.
- R3: Data bits arrive least significant first and are sampled at the centre of each bit. `wlen` sets the word length: 0→5, 1→6, 2→7, 3→8 bits. Unused upper bits of `rd_data` read 0.
- R4: With `par_en`=1 a parity bit follows the data. With `par_even`=1 the data bits plus the parity bit must hold an even number of ones; with `par_even`=0, an odd number. `rd_perr`=1 marks a mismatch. With `par_en`=0 there is no parity bit and `rd_perr`=0.
- R5: A stop bit sampled low sets `rd_ferr`=1 for that character. A stop bit sampled high gives `rd_ferr`=0.
- R6: A frame in which every sampled bit is low (start, data, parity if enabled, stop) is queued with `rd_brk`=1, `rd_ferr`=1 and data 0. No further frame starts until `rxd` has returned high.
- R7: The queue holds 16 characters and returns them in arrival order. `data_ready` is 1 exactly when `fifo_count` is nonzero. A `rd_en` pulse removes the head entry. `rd_en` while the queue is empty has no effect.
- R8: If a character completes while 16 entries are held (counted before any read in the same cycle), `ovr_pulse` is 1 for one cycle, the new character is discarded, and the queued entries are unchanged.
- R9: `timeout` rises once the queue is non-empty and, for four frame times (frame time = 16 strobes × (start + data + parity + stop bits)), no character has been queued and no entry has been read. It falls on the next read or queued character.
- R10: `rx_rdy_n` is 0 when `fifo_count` reaches the level chosen by `trig_sel` (0→1, 1→4, 2→8, 3→14) or when `timeout` is 1. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Strobe at 16× the bit rate |
| rxd | input | 1 | Serial receive line, idles high |
| wlen | input | 2 | Word length select (5..8 bits) |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 = even parity, 0 = odd |
| trig_sel | input | 2 | Fill level for `rx_rdy_n` |
| rd_en | input | 1 | Pop the head entry |
| rd_data | output | 8 | Head entry data |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| rd_brk | output | 1 | Head entry break |
| data_ready | output | 1 | Queue non-empty |
| fifo_count | output | 5 | Entries held |
| ovr_pulse | output | 1 | Character lost to a full queue |
| timeout | output | 1 | Character timeout |
| rx_rdy_n | output | 1 | Active-low receive ready |

## Verification
The bench targets the following corner cases, each paired with the wrong behaviour it would catch:
- Short low glitches on the line: a receiver that skips the mid-start check would queue junk bytes.
- A line held low for twelve bit times: a break detector that rearms on a low level would queue a second break entry.
- Five-bit words sent with all-ones data: a wrong word-length decode would leak stop or parity bits into the upper data bits.
- A seventeenth character sent into a full queue: the bench expects one overrun pulse and an untouched head entry, so a design that overwrites would fail.
- The timeout window, probed just before and just after four frame times: a counter of the wrong length would show up there.
- Random words, parity modes and error injections, compared entry by entry, to catch flag misplacement.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH    = 16,
  parameter int TO_CHARS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick16,
  input  logic                         rxd,
  input  logic [1:0]                   wlen,
  input  logic                         par_en,
  input  logic                         par_even,
  input  logic [1:0]                   trig_sel,
  input  logic                         rd_en,
  output logic [7:0]                   rd_data,
  output logic                         rd_perr,
  output logic                         rd_ferr,
  output logic                         rd_brk,
  output logic                         data_ready,
  output logic [$clog2(DEPTH+1)-1:0]   fifo_count,
  output logic                         ovr_pulse,
  output logic                         timeout,
  output logic                         rx_rdy_n
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(TO_CHARS * 16 * 11 + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t        st;
  logic [3:0] cnt;
  logic [2:0] bitn;
  logic [7:0] sh;
  logic       px, allz, prev, perr_q;

  wire       mid      = tick16 && cnt == 4'hf;
  wire [2:0] last_bit = 3'd4 + {1'b0, wlen};
  wire       push     = st == S_STOP && mid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bitn <= '0; sh <= '0;
      px <= 1'b0; allz <= 1'b0; prev <= 1'b1; perr_q <= 1'b0;
    end else if (tick16) begin
      prev <= rxd;
      case (st)
        S_IDLE: if (prev && !rxd) begin st <= S_START; cnt <= 4'd8; end
        S_START: begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'hf) begin
            if (rxd) st <= S_IDLE;
            else begin
              st <= S_DATA; bitn <= '0; sh <= '0;
              px <= 1'b0; allz <= 1'b1; perr_q <= 1'b0;
            end
          end
        end
        S_DATA: begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'hf) begin
            sh[bitn] <= rxd;
            px       <= px ^ rxd;
            allz     <= allz & ~rxd;
            if (bitn == last_bit) st <= par_en ? S_PAR : S_STOP;
            else bitn <= bitn + 3'd1;
          end
        end
        S_PAR: begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'hf) begin
            perr_q <= par_even ? (px ^ rxd) : ~(px ^ rxd);
            allz   <= allz & ~rxd;
            st     <= S_STOP;
          end
        end
        default: begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'hf) st <= S_IDLE;
        end
      endcase
    end
  end

  logic [10:0]   mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt_f;

  wire full = cnt_f == CW'(DEPTH);
  wire pop  = rd_en && cnt_f != '0;
  wire wr   = push && !full;

  always_ff @(posedge clk)
    if (wr) mem[wp] <= {allz & ~rxd, ~rxd, perr_q, sh};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt_f <= '0; ovr_pulse <= 1'b0;
    end else begin
      if (wr)  wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      if (pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      cnt_f     <= cnt_f + CW'(wr) - CW'(pop);
      ovr_pulse <= push && full;
    end
  end

  assign {rd_brk, rd_ferr, rd_perr, rd_data} = (cnt_f != '0) ? mem[rp] : 11'd0;
  assign data_ready = cnt_f != '0;
  assign fifo_count = cnt_f;

  logic [TW-1:0] tcnt;
  wire  [3:0]    frame_bits = 4'd7 + {2'b00, wlen} + {3'b000, par_en};
  wire  [TW-1:0] tlim       = TW'(TO_CHARS * 16) * TW'(frame_bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tcnt <= '0;
    else if (push || pop || cnt_f == '0) tcnt <= '0;
    else if (tick16 && tcnt < tlim) tcnt <= tcnt + TW'(1);
  end

  assign timeout = cnt_f != '0 && tcnt >= tlim;

  logic [CW-1:0] trig;
  always_comb
    case (trig_sel)
      2'd0:    trig = CW'(1);
      2'd1:    trig = CW'(4);
      2'd2:    trig = CW'(8);
      default: trig = CW'(14);
    endcase

  assign rx_rdy_n = !(cnt_f >= trig || timeout);

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_f <= CW'(DEPTH));
  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cnt_f == '0 && !push) |=> (cnt_f == '0));
  p_overrun_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !rd_en) |=> (ovr_pulse && cnt_f == CW'(DEPTH) && $stable(rp)));
  p_false_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && mid && rxd) |=> (st == S_IDLE));
  p_break_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && rd_brk) |-> (rd_ferr && rd_data == 8'h00));
  p_timeout_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> data_ready);
endmodule

// File: tb/uart_rx_fifo_bench.sv
module uart_rx_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICKDIV    = 2;
  localparam int BT         = 16 * TICKDIV;

  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rxd = 1'b1;
  logic [1:0] wlen = 2'd3, trig_sel = 2'd3;
  logic par_en = 1'b0, par_even = 1'b1, rd_en = 1'b0;
  logic [7:0] rd_data;
  logic rd_perr, rd_ferr, rd_brk, data_ready, ovr_pulse, timeout, rx_rdy_n;
  logic [4:0] fifo_count;

  uart_rx_fifo u_uart_rx_fifo (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .wlen(wlen),
    .par_en(par_en), .par_even(par_even), .trig_sel(trig_sel), .rd_en(rd_en),
    .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
    .data_ready(data_ready), .fifo_count(fifo_count), .ovr_pulse(ovr_pulse),
    .timeout(timeout), .rx_rdy_n(rx_rdy_n));

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(negedge clk) tick16 <= ~tick16;

  int total = 0, bad = 0, ovr_seen = 0, ovr_exp = 0, seed_dummy;
  bit done = 1'b0;
  logic [10:0] model [16];
  int mhead = 0, mcount = 0;

  always @(posedge clk) if (rst_n && ovr_pulse) ovr_seen++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] exp_entry(input logic [7:0] d, input bit bp, input bit bs);
    logic [7:0] m, dm;
    logic pb;
    m  = 8'hFF >> (3 - wlen);
    dm = d & m;
    pb = par_even ? ^dm : ~^dm;
    if (bp) pb = ~pb;
    return {bs && dm == 8'h00 && (!par_en || !pb), bs, par_en && bp, dm};
  endfunction

  task automatic send_frame(input logic [7:0] d, input bit bp, input bit bs);
    logic [7:0] dm;
    logic pb;
    dm = d & (8'hFF >> (3 - wlen));
    pb = par_even ? ^dm : ~^dm;
    if (bp) pb = ~pb;
    rxd = 1'b0; repeat (BT) @(negedge clk);
    for (int i = 0; i < 5 + int'(wlen); i++) begin
      rxd = dm[i]; repeat (BT) @(negedge clk);
    end
    if (par_en) begin rxd = pb; repeat (BT) @(negedge clk); end
    rxd = !bs; repeat (BT) @(negedge clk);
    rxd = 1'b1; repeat (BT) @(negedge clk);
    if (mcount == 16) ovr_exp++;
    else begin
      model[(mhead + mcount) % 16] = exp_entry(d, bp, bs);
      mcount++;
    end
  endtask

  task automatic pop_check(input string req);
    logic [10:0] got;
    got = {rd_brk, rd_ferr, rd_perr, rd_data};
    chk(data_ready == 1'b1, "R7 data_ready", int'(data_ready), 1);
    chk(got == model[mhead], req, int'(got), int'(model[mhead]));
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    mhead = (mhead + 1) % 16; mcount--;
  endtask

  task automatic drain(input string req);
    while (mcount > 0) pop_check(req);
    chk(fifo_count == 5'd0, "R7 empty after drain", int'(fifo_count), 0);
  endtask

  initial begin
    seed_dummy = int'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fifo_count == 0 && !data_ready, "R1 empty", int'(fifo_count), 0);
    chk(!timeout && rx_rdy_n, "R1 timeout/rdy", int'({timeout, rx_rdy_n}), 1);
    chk({rd_brk, rd_ferr, rd_perr, rd_data} == 11'd0, "R1 head zero", int'(rd_data), 0);
    repeat (BT) @(negedge clk);

    wlen = 2'd3; par_en = 1'b0;
    send_frame(8'hA5, 1'b0, 1'b0);
    chk(fifo_count == 5'd1, "R3 one entry", int'(fifo_count), 1);
    pop_check("R3 8-bit word");
    wlen = 2'd0;
    send_frame(8'hFF, 1'b0, 1'b0);
    pop_check("R3 5-bit word upper zero");
    wlen = 2'd1;
    send_frame(8'hC6, 1'b0, 1'b0);
    pop_check("R3 6-bit word");

    rxd = 1'b0; repeat (6 * TICKDIV) @(negedge clk);
    rxd = 1'b1; repeat (2 * BT) @(negedge clk);
    chk(fifo_count == 5'd0, "R2 short glitch rejected", int'(fifo_count), 0);
    rxd = 1'b0; repeat (7 * TICKDIV - 1) @(negedge clk);
    rxd = 1'b1; repeat (2 * BT) @(negedge clk);
    chk(fifo_count == 5'd0, "R2 near-half glitch rejected", int'(fifo_count), 0);
    wlen = 2'd3;
    send_frame(8'h3C, 1'b0, 1'b0);
    pop_check("R2 frame after glitch");

    par_en = 1'b1; par_even = 1'b1;
    send_frame(8'h17, 1'b0, 1'b0);
    send_frame(8'h17, 1'b1, 1'b0);
    par_even = 1'b0;
    send_frame(8'h81, 1'b0, 1'b0);
    send_frame(8'h81, 1'b1, 1'b0);
    drain("R4 parity flag");
    par_en = 1'b0;
    send_frame(8'h5A, 1'b0, 1'b1);
    pop_check("R5 framing error");

    rxd = 1'b0; repeat (12 * BT) @(negedge clk);
    rxd = 1'b1; repeat (2 * BT) @(negedge clk);
    chk(fifo_count == 5'd1, "R6 single break entry", int'(fifo_count), 1);
    model[(mhead + mcount) % 16] = 11'b110_0000_0000; mcount++;
    pop_check("R6 break flags");

    for (int b = 0; b < 5; b++) begin
      int n;
      wlen = 2'($urandom_range(0, 3));
      par_en = 1'($urandom_range(0, 1));
      par_even = 1'($urandom_range(0, 1));
      n = int'($urandom_range(3, 9));
      for (int k = 0; k < n; k++)
        send_frame(8'($urandom), $urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0);
      chk(int'(fifo_count) == n, "R7 count", int'(fifo_count), n);
      drain("R7 random order/flags");
    end

    wlen = 2'd3; par_en = 1'b0; trig_sel = 2'd1;
    for (int k = 0; k < 3; k++) send_frame(8'(k + 1), 1'b0, 1'b0);
    chk(rx_rdy_n == 1'b1, "R10 below level 4", int'(rx_rdy_n), 1);
    send_frame(8'h44, 1'b0, 1'b0);
    chk(rx_rdy_n == 1'b0, "R10 at level 4", int'(rx_rdy_n), 0);
    drain("R10 drain");
    trig_sel = 2'd3;

    for (int k = 0; k < 17; k++) send_frame(8'(8'h10 + k), 1'b0, 1'b0);
    chk(fifo_count == 5'd16, "R8 full count", int'(fifo_count), 16);
    chk(ovr_seen == ovr_exp && ovr_exp == 1, "R8 overrun pulse", ovr_seen, 1);
    chk(rx_rdy_n == 1'b0, "R10 level 14", int'(rx_rdy_n), 0);
    drain("R8 contents kept");
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; @(negedge clk);
    chk(fifo_count == 5'd0 && !data_ready, "R7 read when empty ignored", int'(fifo_count), 0);

    send_frame(8'h21, 1'b0, 1'b0);
    send_frame(8'h22, 1'b0, 1'b0);
    repeat (4 * 16 * 10 * TICKDIV - 48 - 40) @(negedge clk);
    chk(timeout == 1'b0, "R9 no timeout early", int'(timeout), 0);
    chk(rx_rdy_n == 1'b1, "R10 idle below level", int'(rx_rdy_n), 1);
    repeat (80) @(negedge clk);
    chk(timeout == 1'b1, "R9 timeout raised", int'(timeout), 1);
    chk(rx_rdy_n == 1'b0, "R10 ready on timeout", int'(rx_rdy_n), 0);
    pop_check("R9 head before read");
    chk(timeout == 1'b0 && data_ready, "R9 read clears timeout", int'(timeout), 0);
    drain("R9 drain");
    chk(ovr_seen == ovr_exp, "R8 no stray overrun", ovr_seen, ovr_exp);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1-chain actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule